// File: doc/BRIEF.md
# Extended-Frame Envelope Reassembler

This block sits behind a CAN controller that receives 2.0B extended frames. Each received frame (a 29-bit identifier, a length of 0 to 8 and up to 8 data bytes) enters through a valid/ready frame port. The block splits the identifier into its fields. It sends plain one-frame messages straight to a valid/ready byte stream. Messages that span several frames are rebuilt into one byte stream and checked against a 16-bit CRC. Such a message is wrapped in an envelope: it opens with a head frame and closes with a tail frame.

Each output beat carries one byte, a start-of-message marker, an end-of-message marker and a bad-status flag. It also carries the device and stream numbers of the message. One output byte is always held back, so the end marker and the status can ride on the last real payload byte. A saturating counter at a plain output counts every frame the block drops and every envelope it rejects.

Back-pressure rules:
- A frame is taken on a clock edge where `in_valid` and `in_ready` are both high.
- A byte is taken on a clock edge where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, the beat on the output is held unchanged.
- `in_ready` stays low while a frame is being unpacked or a message is being closed.
- `in_ready` may depend on the continuation bit of the frame on offer. An open envelope is closed before a new message is taken.

Top module: `can_env_reasm`

## Requirements
- R1: Identifier fields, from bit 28 down: priority [28:27], direction [26], device [25:18], stream [17:8], sequence [7:1], continuation [0]. Every output beat of a message carries the device (`out_dev`) and stream (`out_stream`) of the frame that opened it.
- R2: A frame is a one-frame message when its continuation bit is 0, it is not a head, and its length is at least 1.
  - Its bytes leave in the order byte 0 (`in_data[7:0]`) first, then byte 1, and so on.
  - The first beat has `out_sop`=1. The last beat has `out_eop`=1 and `out_bad`=0.
  - A length above 8 is treated as 8.
  - Such a frame with length 0 is dropped and counted as an error.
- R3: A head is a frame with continuation 0, length of at least 3, and bytes 0 and 1 both equal to 0x00 (the 16-bit control ID is read little-endian).
  - Byte 2 is the total number of frames in the envelope, head and tail included.
  - A count of 0 or 1 makes the head be dropped, counted as an error, and produce no output.
- R4: In an envelope of N frames, frames 2 to N-1 are pure payload, sent as one message with start and end markers.
  - Frame N must be a tail: continuation 1, length of at least 4, byte 0 = 0x01, byte 1 = 0x00.
  - The tail carries the CRC in byte 2 (low) and byte 3 (high).
  - An envelope with no payload bytes produces no beats.
- R5: The CRC is computed over all payload bytes in arrival order: polynomial 0x1021, initial value 0xFFFF, MSB first, no reflection, no final XOR. A mismatch sets `out_bad`=1 on the end beat and counts one error.
- R6: Each frame after the head must carry sequence = previous + 1, modulo 128. A break closes the envelope: the last byte already received is sent with `out_eop`=1 and `out_bad`=1, the breaking frame is dropped, and one error is counted.
- R7: A frame with continuation 1 that arrives while no envelope is open is dropped and counted as an error, and it produces no output.
- R8: A frame with continuation 0 that arrives while an envelope is open first closes that envelope as bad (one error). The new frame is then taken and handled normally.
- R9: If frame N of an envelope is not a valid tail, the envelope is closed as bad, that frame's bytes are not sent, and one error is counted.
- R10: While `out_valid`=1 and `out_ready`=0, the beat stays stable on the next cycle. `in_ready` is 0 whenever `out_valid` is 1.
- R11: `err_count` rises by at most one per cycle, never falls, and stops at its maximum value (255 by default).
- R12: After reset, `out_valid`=0, `err_count`=0, and `in_ready`=1 for a frame with continuation 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame is on offer |
| in_ready | output | 1 | The block takes the offered frame |
| in_id | input | 29 | Extended identifier |
| in_len | input | 4 | Data length (values above 8 are treated as 8) |
| in_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| out_valid | output | 1 | An output byte is on offer |
| out_ready | input | 1 | The sink takes the byte |
| out_data | output | 8 | Payload byte |
| out_sop | output | 1 | First byte of a message |
| out_eop | output | 1 | Last byte of a message |
| out_bad | output | 1 | On the end beat: the message was rejected |
| out_dev | output | 8 | Device field of the message |
| out_stream | output | 10 | Stream field of the message |
| err_count | output | 8 | Saturating count of dropped frames and rejected envelopes |

## Verification
The bound checker watches the output handshake on every cycle:
- a stalled beat stays stable;
- `in_ready` is low while a byte is on offer;
- every message opens with exactly one start beat;
- device and stream do not change inside a message;
- a bad flag appears only on an end beat;
- the error count climbs by at most one per cycle.

Some behaviour can only be shown by the bench's scenarios, which sweep one-frame lengths and envelope sizes across the sequence wrap, with and without back-pressure:
- the right bytes come out in the right order;
- the CRC verdict is correct;
- head and tail frames are recognised;
- sequence breaks, interruptions and missing tails are handled;
- orphan frames are discarded.

// File: rtl/can_env_pkg.sv
package can_env_pkg;

  typedef struct packed {
    logic [1:0] prio;
    logic       dir;
    logic [7:0] dev;
    logic [9:0] stream;
    logic [6:0] seq;
    logic       cont;
  } xid_t;

  typedef enum logic [1:0] {ST_IDLE, ST_UNPACK, ST_FLUSH} rs_state_t;

  localparam logic [15:0] CTRL_HEAD = 16'h0000;
  localparam logic [15:0] CTRL_TAIL = 16'h0001;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY  = 16'h1021;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ({r[14:0], 1'b0} ^ CRC_POLY) : {r[14:0], 1'b0};
    return r;
  endfunction

endpackage

// File: rtl/can_env_classify.sv
module can_env_classify
  import can_env_pkg::*;
#(
  parameter int BYTES = 8,
  localparam int LEN_W = $clog2(BYTES) + 1,
  localparam int DATA_W = BYTES * 8
) (
  input  logic [28:0]       id,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] data,
  output xid_t              fld,
  output logic [LEN_W-1:0]  eff_len,
  output logic              head_shape,
  output logic              tail_shape,
  output logic [7:0]        head_count,
  output logic [15:0]       tail_crc
);
  logic [15:0] ctrl_id;

  assign fld        = xid_t'(id);
  assign eff_len    = (len > LEN_W'(BYTES)) ? LEN_W'(BYTES) : len;
  assign ctrl_id    = data[15:0];
  assign head_shape = (eff_len >= LEN_W'(3)) && (ctrl_id == CTRL_HEAD);
  assign tail_shape = (eff_len >= LEN_W'(4)) && (ctrl_id == CTRL_TAIL);
  assign head_count = data[23:16];
  assign tail_crc   = data[31:16];
endmodule

// File: rtl/can_env_crc16.sv
module can_env_crc16
  import can_env_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= CRC_SEED;
    else if (en)       crc <= crc16_byte(crc, din);
  end
endmodule

// File: rtl/can_env_satcnt.sv
module can_env_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/can_env_reasm.sv
module can_env_reasm
  import can_env_pkg::*;
#(
  parameter int BYTES = 8,
  parameter int CNT_W = 8,
  localparam int LEN_W = $clog2(BYTES) + 1,
  localparam int IDX_W = $clog2(BYTES),
  localparam int DATA_W = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [28:0]       in_id,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_bad,
  output logic [7:0]        out_dev,
  output logic [9:0]        out_stream,
  output logic [CNT_W-1:0]  err_count
);
  xid_t             fld;
  logic [LEN_W-1:0] eff_len;
  logic             head_shape, tail_shape;
  logic [7:0]       head_count;
  logic [15:0]      tail_crc, crc;

  can_env_classify #(.BYTES(BYTES)) u_cls (
    .id(in_id), .len(in_len), .data(in_data), .fld(fld), .eff_len(eff_len),
    .head_shape(head_shape), .tail_shape(tail_shape),
    .head_count(head_count), .tail_crc(tail_crc)
  );

  rs_state_t         state_q;
  logic              env_open_q, in_env_q, hold_v_q, first_q, bad_q;
  logic [7:0]        env_total_q, env_seen_q, hold_b_q, dev_q;
  logic [6:0]        env_seq_q;
  logic [9:0]        stream_q;
  logic [DATA_W-1:0] fbuf_q;
  logic [LEN_W-1:0]  flen_q;
  logic [IDX_W-1:0]  fidx_q;

  // decisions for a frame on offer while idle
  logic ev, d_orphan, d_head, d_head_bad, d_single, d_empty;
  logic d_interrupt, d_seqbrk, d_final, d_tail_ok, d_crc_bad, d_notail, d_mid;
  logic err_inc, byte_step, last_byte;
  logic [7:0] cur_byte;

  always_comb begin
    ev          = in_valid && (state_q == ST_IDLE);
    d_orphan    = ev && !env_open_q && fld.cont;
    d_head      = ev && !env_open_q && !fld.cont && head_shape;
    d_head_bad  = d_head && (head_count < 8'd2);
    d_single    = ev && !env_open_q && !fld.cont && !head_shape && (eff_len != '0);
    d_empty     = ev && !env_open_q && !fld.cont && !head_shape && (eff_len == '0);
    d_interrupt = ev && env_open_q && !fld.cont;
    d_seqbrk    = ev && env_open_q && fld.cont && (fld.seq != env_seq_q + 7'd1);
    d_final     = ev && env_open_q && fld.cont && !d_seqbrk &&
                  (env_seen_q == env_total_q - 8'd1);
    d_tail_ok   = d_final && tail_shape;
    d_crc_bad   = d_tail_ok && (tail_crc != crc);
    d_notail    = d_final && !tail_shape;
    d_mid       = ev && env_open_q && fld.cont && !d_seqbrk && !d_final;
    err_inc     = d_orphan || d_head_bad || d_empty || d_interrupt ||
                  d_seqbrk || d_notail || d_crc_bad;
  end

  assign in_ready  = (state_q == ST_IDLE) && !(env_open_q && !fld.cont);
  assign cur_byte  = fbuf_q[{fidx_q, 3'b000} +: 8];
  assign byte_step = (state_q == ST_UNPACK) && (!hold_v_q || out_ready);
  assign last_byte = (LEN_W'(fidx_q) + 1'b1 == flen_q);

  assign out_valid  = hold_v_q && (state_q != ST_IDLE);
  assign out_data   = hold_b_q;
  assign out_sop    = first_q;
  assign out_eop    = (state_q == ST_FLUSH);
  assign out_bad    = (state_q == ST_FLUSH) && bad_q;
  assign out_dev    = dev_q;
  assign out_stream = stream_q;

  can_env_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(d_head && !d_head_bad),
    .en(byte_step && in_env_q), .din(cur_byte), .crc(crc)
  );

  can_env_satcnt #(.W(CNT_W)) u_err (
    .clk(clk), .rst_n(rst_n), .inc(err_inc), .cnt(err_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      env_open_q  <= 1'b0;
      in_env_q    <= 1'b0;
      hold_v_q    <= 1'b0;
      first_q     <= 1'b0;
      bad_q       <= 1'b0;
      env_total_q <= '0;
      env_seen_q  <= '0;
      env_seq_q   <= '0;
      hold_b_q    <= '0;
      dev_q       <= '0;
      stream_q    <= '0;
      fbuf_q      <= '0;
      flen_q      <= '0;
      fidx_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (d_head && !d_head_bad) begin
            env_open_q  <= 1'b1;
            env_total_q <= head_count;
            env_seen_q  <= 8'd1;
            env_seq_q   <= fld.seq;
            dev_q       <= fld.dev;
            stream_q    <= fld.stream;
            first_q     <= 1'b1;
          end
          if (d_single) begin
            fbuf_q   <= in_data;
            flen_q   <= eff_len;
            fidx_q   <= '0;
            in_env_q <= 1'b0;
            dev_q    <= fld.dev;
            stream_q <= fld.stream;
            first_q  <= 1'b1;
            state_q  <= ST_UNPACK;
          end
          if (d_interrupt || d_seqbrk || d_notail) begin
            env_open_q <= 1'b0;
            bad_q      <= 1'b1;
            state_q    <= ST_FLUSH;
          end
          if (d_tail_ok) begin
            env_open_q <= 1'b0;
            bad_q      <= d_crc_bad;
            state_q    <= ST_FLUSH;
          end
          if (d_mid) begin
            env_seen_q <= env_seen_q + 8'd1;
            env_seq_q  <= fld.seq;
            if (eff_len != '0) begin
              fbuf_q   <= in_data;
              flen_q   <= eff_len;
              fidx_q   <= '0;
              in_env_q <= 1'b1;
              state_q  <= ST_UNPACK;
            end
          end
        end
        ST_UNPACK: begin
          if (byte_step) begin
            hold_b_q <= cur_byte;
            hold_v_q <= 1'b1;
            if (hold_v_q) first_q <= 1'b0;
            fidx_q <= fidx_q + 1'b1;
            if (last_byte) begin
              if (in_env_q) state_q <= ST_IDLE;
              else begin
                bad_q   <= 1'b0;
                state_q <= ST_FLUSH;
              end
            end
          end
        end
        ST_FLUSH: begin
          if (!hold_v_q) state_q <= ST_IDLE;
          else if (out_ready) begin
            hold_v_q <= 1'b0;
            first_q  <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/can_env_reasm_chk.sv
module can_env_reasm_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sop,
  input logic             out_eop,
  input logic             out_bad,
  input logic [7:0]       out_dev,
  input logic [9:0]       out_stream,
  input logic [CNT_W-1:0] err_count
);
  logic       in_msg_q;
  logic [7:0] dev_q;
  logic [9:0] stream_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_msg_q <= 1'b0;
      dev_q    <= '0;
      stream_q <= '0;
    end else if (out_valid && out_ready) begin
      in_msg_q <= !out_eop;
      if (out_sop) begin
        dev_q    <= out_dev;
        stream_q <= out_stream;
      end
    end
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
      && $stable(out_eop) && $stable(out_bad));

  p_no_take_while_send_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R2 / R4: a message opens with one start beat and no start beat inside it
  p_sop_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !in_msg_q |-> out_sop);

  p_sop_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && in_msg_q |-> !out_sop);

  p_dev_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && in_msg_q |-> out_dev == dev_q && out_stream == stream_q);

  p_bad_on_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bad |-> out_eop);

  p_err_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));
endmodule

bind can_env_reasm can_env_reasm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
  .out_bad(out_bad), .out_dev(out_dev), .out_stream(out_stream), .err_count(err_count)
);

// File: tb/can_env_reasm_tb.sv
module can_env_reasm_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [28:0] in_id = '0;
  logic [3:0]  in_len = '0;
  logic [63:0] in_data = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [7:0]  out_data, out_dev, err_count;
  logic        out_sop, out_eop, out_bad;
  logic [9:0]  out_stream;

  can_env_reasm u_dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0, exp_err = 0, cyc = 0, bp_mode = 0;
  logic [28:0] expq[$];
  logic [28:0] gotq[$];
  logic [7:0]  bq[$];

  initial forever begin
    @(posedge clk);
    cyc++;
    out_ready <= (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? (cyc % 3 != 0) : 1'b0;
  end

  always @(negedge clk)
    if (rst_n && out_valid && out_ready)
      gotq.push_back({out_bad, out_eop, out_sop, out_stream, out_dev, out_data});

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [28:0] mk_id(input logic [7:0] dev, input logic [9:0] st,
                                        input logic [6:0] seq, input logic cont);
    return {2'b10, 1'b1, dev, st, seq, cont};
  endfunction

  task automatic send(input logic [28:0] id, input logic [3:0] len, input logic [63:0] d);
    logic acc = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_id = id; in_len = len; in_data = d;
    while (!acc) begin
      #1 acc = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic push_msg(input logic [7:0] dev, input logic [9:0] st, input logic bad);
    for (int k = 0; k < bq.size(); k++)
      expq.push_back({bad && (k == bq.size() - 1), k == bq.size() - 1, k == 0, st, dev, bq[k]});
    bq.delete();
  endtask

  task automatic finish_scn(input string req);
    repeat (60) @(negedge clk);
    check({req, " beat count"}, 64'(gotq.size()), 64'(expq.size()));
    for (int k = 0; k < expq.size() && k < gotq.size(); k++)
      check({req, " beat"}, 64'(gotq[k]), 64'(expq[k]));
    check({req, " error count"}, 64'(err_count), 64'(exp_err));
    gotq.delete(); expq.delete();
  endtask

  task automatic single(input logic [7:0] dev, input logic [9:0] st, input logic [3:0] len, input int seed);
    logic [63:0] d;
    int n = (len > 8) ? 8 : len;
    for (int k = 0; k < 8; k++) d[k*8 +: 8] = 8'(seed * 17 + k * 3 + 1);
    if (d[15:0] == 16'h0000) d[7:0] = 8'h55;
    for (int k = 0; k < n; k++) bq.push_back(d[k*8 +: 8]);
    send(mk_id(dev, st, 7'(seed), 1'b0), len, d);
    push_msg(dev, st, 1'b0);
  endtask

  task automatic envelope(input logic [7:0] dev, input logic [9:0] st, input logic [6:0] seq0,
                          input int nfr, input int seed, input logic corrupt);
    logic [6:0]  seq = seq0;
    logic [15:0] c = 16'hFFFF;
    send(mk_id(dev, st, seq, 1'b0), 4'd3, {40'h0, 8'(nfr + 2), 16'h0000});
    for (int f = 0; f < nfr; f++) begin
      logic [63:0] d = '0;
      int len = (seed + f * 5) % 9;
      for (int k = 0; k < 8; k++) d[k*8 +: 8] = 8'(seed * 29 + f * 13 + k * 7 + 1);
      for (int k = 0; k < len; k++) begin
        bq.push_back(d[k*8 +: 8]);
        c = bcrc(c, d[k*8 +: 8]);
      end
      seq = seq + 7'd1;
      send(mk_id(dev, st, seq, 1'b1), 4'(len), d);
    end
    seq = seq + 7'd1;
    send(mk_id(dev, st, seq, 1'b1), 4'd4, {32'h0, c ^ {15'h0, corrupt}, 16'h0001});
    if (bq.size() > 0) push_msg(dev, st, corrupt);
    else bq.delete();
    if (corrupt) exp_err++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] c;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 out_valid", 64'(out_valid), 64'd0);
    check("R12 err_count", 64'(err_count), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R12 in_ready", 64'(in_ready), 64'd1);

    // R5: bench CRC reference value over "123456789"
    c = 16'hFFFF;
    for (int k = 0; k < 9; k++) c = bcrc(c, 8'(8'h31 + k));
    check("R5 crc reference", 64'(c), 64'h29B1);

    // R1 R2: one-frame messages of every length, with and without stalls
    for (int bp = 0; bp < 2; bp++) begin
      bp_mode = bp;
      for (int len = 1; len <= 9; len++)
        single(8'(len * 11 + bp), 10'(len * 37 + 5), (len == 9) ? 4'd12 : 4'(len), len + bp * 9);
      finish_scn("R2");
    end

    // R4 R5 R6: envelopes of 0..3 payload frames, sequence crossing 127->0
    for (int bp = 0; bp < 2; bp++) begin
      bp_mode = bp;
      for (int nfr = 0; nfr < 4; nfr++)
        for (int seed = 0; seed < 5; seed++)
          envelope(8'(seed + 40), 10'(nfr * 100 + seed), 7'(124 + seed), nfr, seed + bp * 3, 1'b0);
      finish_scn("R4");
    end
    bp_mode = 0;

    // R5: corrupted CRC
    envelope(8'h21, 10'h3A5, 7'd5, 2, 4, 1'b1);
    envelope(8'h22, 10'h001, 7'd126, 3, 2, 1'b1);
    finish_scn("R5");

    // R6: sequence break
    send(mk_id(8'h31, 10'h10, 7'd10, 1'b0), 4'd3, {40'h0, 8'd5, 16'h0});
    send(mk_id(8'h31, 10'h10, 7'd11, 1'b1), 4'd3, 64'h0000_0000_00C3_C2C1);
    send(mk_id(8'h31, 10'h10, 7'd13, 1'b1), 4'd2, 64'h0000_0000_0000_D2D1);
    bq.push_back(8'hC1); bq.push_back(8'hC2); bq.push_back(8'hC3);
    push_msg(8'h31, 10'h10, 1'b1);
    exp_err++;
    finish_scn("R6");

    // R7: orphan continuation frame
    send(mk_id(8'h32, 10'h11, 7'd3, 1'b1), 4'd8, 64'h1122_3344_5566_7788);
    exp_err++;
    finish_scn("R7");

    // R3: head with count 0 and 1; R2: empty one-frame message
    send(mk_id(8'h33, 10'h12, 7'd0, 1'b0), 4'd3, {40'h0, 8'd0, 16'h0});
    send(mk_id(8'h33, 10'h12, 7'd0, 1'b0), 4'd3, {40'h0, 8'd1, 16'h0});
    exp_err += 2;
    finish_scn("R3");
    send(mk_id(8'h34, 10'h13, 7'd0, 1'b0), 4'd0, 64'h0);
    exp_err++;
    finish_scn("R2 empty");

    // R8: a new message interrupts an open envelope
    send(mk_id(8'h35, 10'h14, 7'd20, 1'b0), 4'd3, {40'h0, 8'd4, 16'h0});
    send(mk_id(8'h35, 10'h14, 7'd21, 1'b1), 4'd4, 64'h0000_0000_E4E3_E2E1);
    bq.push_back(8'hE1); bq.push_back(8'hE2); bq.push_back(8'hE3); bq.push_back(8'hE4);
    push_msg(8'h35, 10'h14, 1'b1);
    exp_err++;
    single(8'h36, 10'h15, 4'd2, 7);
    finish_scn("R8");

    // R9: final frame is not a tail
    send(mk_id(8'h37, 10'h16, 7'd0, 1'b0), 4'd3, {40'h0, 8'd3, 16'h0});
    send(mk_id(8'h37, 10'h16, 7'd1, 1'b1), 4'd2, 64'h0000_0000_0000_F2F1);
    send(mk_id(8'h37, 10'h16, 7'd2, 1'b1), 4'd4, 64'h0000_0000_AAAA_0005);
    bq.push_back(8'hF1); bq.push_back(8'hF2);
    push_msg(8'h37, 10'h16, 1'b1);
    exp_err++;
    finish_scn("R9");

    // R10: stall holds the beat and blocks input
    bp_mode = 2;
    repeat (2) @(negedge clk);
    send(mk_id(8'h38, 10'h17, 7'd0, 1'b0), 4'd3, 64'h0000_0000_00A3_A2A1);
    repeat (4) @(negedge clk);
    #1;
    check("R10 valid in stall", 64'(out_valid), 64'd1);
    check("R10 data in stall", 64'(out_data), 64'hA1);
    check("R10 in_ready in stall", 64'(in_ready), 64'd0);
    repeat (3) @(negedge clk);
    #1 check("R10 data still held", 64'({out_valid, out_sop, out_data}), 64'h3A1);
    bq.push_back(8'hA1); bq.push_back(8'hA2); bq.push_back(8'hA3);
    push_msg(8'h38, 10'h17, 1'b0);
    bp_mode = 0;
    finish_scn("R10");

    // R11: error count saturates
    for (int k = 0; k < 300; k++) begin
      send(mk_id(8'h39, 10'h18, 7'(k), 1'b1), 4'd1, 64'h0);
      exp_err = (exp_err < 255) ? exp_err + 1 : 255;
    end
    finish_scn("R11");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule